// File: doc/BRIEF.md
# Doppler Zero-Velocity Bin Suppressor

This block sits on the output of a 16-point Doppler transform and removes the energy that lies near zero velocity. Each incoming complex sample has its own valid strobe and a bin index from 0 to 15. Bin 0 is zero velocity. A programmable half-width W picks how many bins on each side of DC are blanked. The blanked region wraps around DC. It covers the bins from 0 up to W and the bins from 16−W up to 15. That is 2W+1 bins in total. Setting W to 0 turns the stage off.

Every sample comes out exactly one clock later. The bin tag and the valid strobe go with it. A blanked sample keeps its valid strobe, so downstream bin counting is not disturbed. Its I and Q are forced to zero and a flag marks it as suppressed. The limits are 5 bits wide, lower = W and upper = 16−W, and both comparisons are inclusive. This keeps both edges of the region correct for every width.

The width is taken from its input only when bin 0 is accepted. A frame therefore always uses a single width.

Top module: `dc_notch`

## Requirements
- R1: After synchronous reset, out_valid, out_i, out_q and out_notched are 0, and the held width is 0. Samples accepted before the first valid bin 0 pass unchanged.
- R2: out_valid equals in_valid from the previous clock. When the previous in_valid was 1, out_bin equals that cycle's in_bin.
- R3: For a held width W in 1..7, a valid sample with bin ≤ W or bin ≥ 16−W has out_i = out_q = 0 and out_notched = 1. The resulting masks (bit n = bin n) are: W=1 gives 16'h8003, W=3 gives 16'hE00F, W=7 gives 16'hFEFF.
- R4: A valid sample outside the notched set comes out with out_i and out_q equal to its input values and out_notched = 0. Bin 8 is never notched.
- R5: A held width of 0 notches no bin, bin 0 included.
- R6: in_width is captured only when in_valid is 1 and in_bin is 0. The captured value applies to that bin 0 and to every later sample until the next captured bin 0. A change of in_width in the middle of a frame has no effect.
- R7: A notched sample still produces out_valid = 1. A 16-bin frame gives 16 output strobes, even when idle cycles are mixed in.
- R8: When in_valid is 0, no width is captured, even if in_bin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_bin | input | 4 | Doppler bin index of the input sample |
| in_i | input | 16 | In-phase input, signed |
| in_q | input | 16 | Quadrature input, signed |
| in_width | input | 3 | Notch half-width W, captured at bin 0 |
| out_valid | output | 1 | Output sample strobe |
| out_bin | output | 4 | Bin index of the output sample |
| out_i | output | 16 | In-phase output, zero when notched |
| out_q | output | 16 | Quadrature output, zero when notched |
| out_notched | output | 1 | 1 when the output sample was suppressed |

## Verification
Full frames run at widths 1, 3 and 7. Their suppression masks are compared against the exact expected sets. This separates inclusive comparisons from exclusive ones at both the low and the high edge, since an off-by-one drops bins 1, 15, 7 or 9. A zero-width frame and a pre-reset-capture stream show whether bin 0 is gated wrongly when the stage should be off. A width change in mid-frame, and an idle bin 0 carrying a new width, show whether capture happens only on a valid bin 0. Random data with idle gaps, compared every clock against a behavioural model, shows whether pass-through values and strobe counts survive.

// File: rtl/dc_notch_pkg.sv
package dc_notch_pkg;
  typedef enum logic {
    BIN_PASS  = 1'b0,
    BIN_NOTCH = 1'b1
  } bin_fate_e;
endpackage

// File: rtl/dc_notch_width_hold.sv
module dc_notch_width_hold #(
  parameter int BIN_W = 4,
  parameter int WID_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BIN_W-1:0] in_bin,
  input  logic [WID_W-1:0] in_width,
  output logic [WID_W-1:0] eff_width
);
  logic [WID_W-1:0] held_q;
  logic             frame_start;

  assign frame_start = in_valid && (in_bin == '0);
  // the frame-opening bin already uses the freshly presented width
  assign eff_width = frame_start ? in_width : held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (frame_start) begin
      held_q <= in_width;
    end
  end
endmodule

// File: rtl/dc_notch_classify.sv
module dc_notch_classify
  import dc_notch_pkg::*;
#(
  parameter int NUM_BINS = 16,
  parameter int BIN_W    = 4,
  parameter int WID_W    = 3
) (
  input  logic [BIN_W-1:0] bin,
  input  logic [WID_W-1:0] width,
  output bin_fate_e        fate
);
  localparam int LIM_W = BIN_W + 1;

  logic [LIM_W-1:0] lim_lo;
  logic [LIM_W-1:0] lim_hi;
  logic [LIM_W-1:0] bin_ext;
  logic             enabled;

  assign enabled = (width != '0);
  assign lim_lo  = LIM_W'(width);
  assign lim_hi  = LIM_W'(NUM_BINS) - LIM_W'(width);
  assign bin_ext = LIM_W'(bin);

  always_comb begin
    fate = BIN_PASS;
    if (enabled && ((bin_ext <= lim_lo) || (bin_ext >= lim_hi))) begin
      fate = BIN_NOTCH;
    end
  end
endmodule

// File: rtl/dc_notch_out_stage.sv
module dc_notch_out_stage
  import dc_notch_pkg::*;
#(
  parameter int BIN_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [BIN_W-1:0]         in_bin,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  bin_fate_e                fate,
  output logic                     out_valid,
  output logic [BIN_W-1:0]         out_bin,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q,
  output logic                     out_notched
);
  logic kill;
  assign kill = (fate == BIN_NOTCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_bin     <= '0;
      out_i       <= '0;
      out_q       <= '0;
      out_notched <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_bin     <= in_bin;
        out_i       <= kill ? '0 : in_i;
        out_q       <= kill ? '0 : in_q;
        out_notched <= kill;
      end
    end
  end
endmodule

// File: rtl/dc_notch.sv
module dc_notch
  import dc_notch_pkg::*;
#(
  parameter int NUM_BINS = 16,
  parameter int DATA_W   = 16,
  parameter int WID_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [$clog2(NUM_BINS)-1:0] in_bin,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic [WID_W-1:0]         in_width,
  output logic                     out_valid,
  output logic [$clog2(NUM_BINS)-1:0] out_bin,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q,
  output logic                     out_notched
);
  localparam int BIN_W = $clog2(NUM_BINS);

  logic [WID_W-1:0] eff_width;
  bin_fate_e        fate;

  dc_notch_width_hold #(.BIN_W(BIN_W), .WID_W(WID_W)) u_hold (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bin(in_bin),
    .in_width(in_width), .eff_width(eff_width)
  );

  dc_notch_classify #(.NUM_BINS(NUM_BINS), .BIN_W(BIN_W), .WID_W(WID_W)) u_cls (
    .bin(in_bin), .width(eff_width), .fate(fate)
  );

  dc_notch_out_stage #(.BIN_W(BIN_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bin(in_bin),
    .in_i(in_i), .in_q(in_q), .fate(fate),
    .out_valid(out_valid), .out_bin(out_bin), .out_i(out_i),
    .out_q(out_q), .out_notched(out_notched)
  );
endmodule

// File: rtl/dc_notch_chk.sv
module dc_notch_chk #(
  parameter int NUM_BINS = 16,
  parameter int DATA_W   = 16,
  parameter int WID_W    = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [$clog2(NUM_BINS)-1:0] in_bin,
  input logic signed [DATA_W-1:0] in_i,
  input logic signed [DATA_W-1:0] in_q,
  input logic [WID_W-1:0]         in_width,
  input logic                     out_valid,
  input logic [$clog2(NUM_BINS)-1:0] out_bin,
  input logic signed [DATA_W-1:0] out_i,
  input logic signed [DATA_W-1:0] out_q,
  input logic                     out_notched
);
  localparam int BIN_W = $clog2(NUM_BINS);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_bin_carried_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_bin == $past(in_bin)));
  assert_notch_zeroes_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_notched) |-> (out_i == '0 && out_q == '0));
  assert_pass_data_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_notched || (out_i == $past(in_i) && out_q == $past(in_q))));
  assert_mid_bin_open_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bin == BIN_W'(NUM_BINS / 2)) |-> !out_notched);
  assert_zero_width_off_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_bin == '0 && in_width == '0) |=> !out_notched);
  assert_open_frame_dc_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_bin == '0 && in_width != '0) |=> out_notched);
endmodule

bind dc_notch dc_notch_chk #(.NUM_BINS(NUM_BINS), .DATA_W(DATA_W), .WID_W(WID_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_bin(in_bin), .in_i(in_i),
  .in_q(in_q), .in_width(in_width), .out_valid(out_valid), .out_bin(out_bin),
  .out_i(out_i), .out_q(out_q), .out_notched(out_notched)
);

// File: tb/tb_dc_notch.sv
`timescale 1ns/1ps
module tb_dc_notch;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic [3:0]         in_bin = '0;
  logic signed [15:0] in_i = '0;
  logic signed [15:0] in_q = '0;
  logic [2:0]         in_width = '0;
  logic               out_valid;
  logic [3:0]         out_bin;
  logic signed [15:0] out_i;
  logic signed [15:0] out_q;
  logic               out_notched;

  int checks = 0;
  int failures = 0;
  string cur_req = "R2";

  // behavioural reference
  int ref_w = 0;
  logic               e_valid = 1'b0;
  logic [3:0]         e_bin = '0;
  logic signed [15:0] e_i = '0;
  logic signed [15:0] e_q = '0;
  logic               e_n = 1'b0;

  logic [15:0] mask = '0;
  int vcount = 0;
  bit done = 0;

  dc_notch dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bin(in_bin), .in_i(in_i),
    .in_q(in_q), .in_width(in_width), .out_valid(out_valid), .out_bin(out_bin),
    .out_i(out_i), .out_q(out_q), .out_notched(out_notched)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ref_w = 0;
      e_valid <= 1'b0; e_bin <= '0; e_i <= '0; e_q <= '0; e_n <= 1'b0;
    end else begin
      e_valid <= in_valid;
      if (in_valid) begin
        bit nb;
        if (in_bin == 4'd0) ref_w = int'(in_width);
        nb = (ref_w != 0) && ((int'(in_bin) <= ref_w) || (int'(in_bin) >= 16 - ref_w));
        e_bin <= in_bin;
        e_i <= nb ? 16'sd0 : in_i;
        e_q <= nb ? 16'sd0 : in_q;
        e_n <= nb;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(out_valid == e_valid, "R2", "out_valid", out_valid, e_valid);
      if (e_valid) begin
        check(out_bin == e_bin, "R2", "out_bin", out_bin, e_bin);
        check(out_i == e_i && out_q == e_q, cur_req, "data",
              {out_i, out_q}, {e_i, e_q});
        check(out_notched == e_n, cur_req, "notched", out_notched, e_n);
      end
      if (out_valid) begin
        vcount++;
        if (out_notched) mask[out_bin] = 1'b1;
      end
    end
  end

  task automatic send(input int bin, input int w, input bit v);
    @(negedge clk);
    in_valid = v;
    in_bin = 4'(bin);
    in_width = 3'(w);
    in_i = 16'($urandom);
    in_q = 16'($urandom);
    if (in_i == 0) in_i = 16'sd1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    idle();
    @(negedge clk);
    #0.5;
  endtask

  task automatic frame(input int w, input int mid_w, input bit gaps);
    mask = '0; vcount = 0;
    for (int b = 0; b < 16; b++) begin
      send(b, (b == 0) ? w : mid_w, 1'b1);
      if (gaps && (b % 3 == 1)) idle();
    end
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    check(out_i == 0 && out_q == 0, "R1", "reset data", {out_i, out_q}, 0);
    check(out_notched == 1'b0, "R1", "reset notched", out_notched, 0);
    @(negedge clk);
    rst = 1'b0;

    // R1: no bin 0 yet, held width 0 -> pass
    cur_req = "R1"; mask = '0;
    send(1, 7, 1'b1); send(5, 7, 1'b1); send(15, 7, 1'b1);
    settle();
    check(mask == 16'h0000, "R1", "pre-capture mask", mask, 16'h0000);

    cur_req = "R3";
    frame(1, 1, 1'b0);
    check(mask == 16'h8003, "R3", "mask W=1", mask, 16'h8003);
    frame(3, 3, 1'b0);
    check(mask == 16'hE00F, "R3", "mask W=3", mask, 16'hE00F);
    frame(7, 7, 1'b0);
    check(mask == 16'hFEFF, "R3", "mask W=7", mask, 16'hFEFF);
    check(mask[8] == 1'b0, "R4", "bin 8 open", mask[8], 0);

    cur_req = "R5";
    frame(0, 5, 1'b0);
    check(mask == 16'h0000, "R5", "mask W=0", mask, 16'h0000);

    cur_req = "R6";
    frame(1, 7, 1'b0);
    check(mask == 16'h8003, "R6", "mid-frame width ignored", mask, 16'h8003);
    frame(7, 1, 1'b0);
    check(mask == 16'hFEFF, "R6", "new width at bin 0", mask, 16'hFEFF);

    cur_req = "R7";
    frame(5, 5, 1'b1);
    check(vcount == 16, "R7", "strobes per gapped frame", vcount, 16);
    check(mask == 16'hF83F, "R7", "mask W=5 with gaps", mask, 16'hF83F);

    // R8: idle bin 0 with new width must not capture
    cur_req = "R8";
    frame(2, 2, 1'b0);
    check(mask == 16'hC007, "R3", "mask W=2", mask, 16'hC007);
    send(0, 7, 1'b0);
    mask = '0;
    for (int b = 1; b < 16; b++) send(b, 7, 1'b1);
    settle();
    check(mask == 16'hC006, "R8", "idle bin 0 no capture", mask, 16'hC006);

    cur_req = "R4";
    for (int k = 0; k < 20; k++) frame(k % 8, (k * 3) % 8, k[0]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule